// File: doc/BRIEF.md
# Priority Reference Clock Selector

This block decides which of two reference clocks, a primary and a secondary, drives the reference input of a frequency synthesizer. It produces one select line for the clock multiplexer and a small set of status flags. The multiplexer itself and the analog clock detectors are outside this block.

A configuration bit picks one of two modes. In manual mode the select line follows an external select pin, and the pin's idle-high level means the primary reference is chosen. In automatic mode the pin has no effect. The block then watches both references with edge-counting activity monitors that run on the system clock, and it always prefers the primary reference when that clock is alive. When the primary fails, the block moves to the secondary. It returns to the primary only after the primary has proven stable for several measurement windows. If neither reference is alive, the current choice is held and a flag reports the condition. Every change of selection produces a one-cycle pulse.

Top module: `refclk_priority_selector`

## Requirements
- R1: During and right after reset, use_primary is 1, switch_event is 0, pri_valid and sec_valid are 0, and no_reference is 1.
- R2: While auto_mode is 0, use_primary takes the value of sel_pin one clock later (sel_pin 1 = primary, 0 = secondary).
- R3: While auto_mode is 1, the value of sel_pin has no effect on use_primary or switch_event.
- R4: A reference's valid flag rises at the end of a 256-cycle window in which at least one rising edge of that reference was seen, after a two-stage synchronizer.
- R5: A valid flag falls only after two consecutive windows with no rising edge.
- R6: In auto_mode, while the primary is valid and selected, the selection stays on the primary. If the primary becomes invalid while the secondary is valid, the selection moves to the secondary.
- R7: In auto_mode, once on the secondary, the selection returns to the primary only after four consecutive good primary windows. The exception is when the secondary is invalid and the primary is valid; in that case it returns at once.
- R8: When neither reference is valid, no_reference is 1 and, in auto_mode, use_primary holds its value.
- R9: switch_event is high for exactly the one cycle in which use_primary shows a new value, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for monitoring and decision logic |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_ref | input | 1 | Primary reference clock (asynchronous) |
| sec_ref | input | 1 | Secondary reference clock (asynchronous) |
| sel_pin | input | 1 | External select: 1 primary, 0 secondary |
| auto_mode | input | 1 | Configuration bit: 1 enables automatic failover |
| use_primary | output | 1 | Multiplexer select: 1 primary, 0 secondary |
| pri_valid | output | 1 | Primary reference is alive |
| sec_valid | output | 1 | Secondary reference is alive |
| no_reference | output | 1 | Neither reference is alive |
| switch_event | output | 1 | One-cycle pulse on a selection change |

## Verification
A corrupted window counter or miss counter shows up as a valid flag that changes too early or too late. The earliest such error can be seen one window, or 256 cycles, after the reference stops or starts. A wrong hysteresis count shows up as a return to the primary before four windows have passed, which is a switch_event that the scoreboard does not expect. A wrong selection register is visible on use_primary in the very next cycle in manual mode, and within one window boundary in automatic mode.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    localparam int unsigned NUM_REFS = 2;
    localparam int unsigned PRI_IDX  = 0;
    localparam int unsigned SEC_IDX  = 1;

    typedef struct packed {
        logic use_pri;
        logic sw_evt;
    } sel_state_t;
endpackage

// File: rtl/refsel_window_timer.sv
module refsel_window_timer #(
    parameter int unsigned WIN_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic window_end
);
    localparam int unsigned CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign window_end = (cnt_q == LAST);
endmodule

// File: rtl/refsel_activity_mon.sv
module refsel_activity_mon #(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned LOSS_WINDOWS   = 2,
    parameter int unsigned RETURN_WINDOWS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic window_end,
    output logic present,
    output logic qualified
);
    localparam int unsigned MISS_W = $clog2(LOSS_WINDOWS + 1);
    localparam int unsigned GOOD_W = $clog2(RETURN_WINDOWS + 1);
    localparam logic [MISS_W-1:0] MISS_MAX  = MISS_W'(LOSS_WINDOWS);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_WINDOWS - 1);
    localparam logic [GOOD_W-1:0] GOOD_MAX  = GOOD_W'(RETURN_WINDOWS);

    typedef struct packed {
        logic [SYNC_STAGES:0] sync;
        logic                 seen;
        logic [MISS_W-1:0]    miss;
        logic [GOOD_W-1:0]    good;
        logic                 present;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-1:0], ref_in};
        rise      = st_q.sync[SYNC_STAGES-1] & ~st_q.sync[SYNC_STAGES];
        if (window_end) begin
            st_d.seen = 1'b0;
            if (st_q.seen || rise) begin
                st_d.miss    = '0;
                st_d.present = 1'b1;
                if (st_q.good != GOOD_MAX) st_d.good = st_q.good + 1'b1;
            end else begin
                st_d.good = '0;
                if (st_q.miss != MISS_MAX) st_d.miss = st_q.miss + 1'b1;
                if (st_q.miss >= MISS_LAST) st_d.present = 1'b0;
            end
        end else if (rise) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign present   = st_q.present;
    assign qualified = st_q.present && (st_q.good == GOOD_MAX);
endmodule

// File: rtl/refclk_priority_selector.sv
module refclk_priority_selector
    import refsel_pkg::*;
#(
    parameter int unsigned WIN_CYCLES     = 256,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned LOSS_WINDOWS   = 2,
    parameter int unsigned RETURN_WINDOWS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pri_ref,
    input  logic sec_ref,
    input  logic sel_pin,
    input  logic auto_mode,
    output logic use_primary,
    output logic pri_valid,
    output logic sec_valid,
    output logic no_reference,
    output logic switch_event
);
    logic                window_end;
    logic [NUM_REFS-1:0] ref_vec;
    logic [NUM_REFS-1:0] pres;
    logic [NUM_REFS-1:0] qual;
    sel_state_t          sel_d, sel_q;
    logic                next_pri;

    assign ref_vec[PRI_IDX] = pri_ref;
    assign ref_vec[SEC_IDX] = sec_ref;

    refsel_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .window_end (window_end)
    );

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_mon
        refsel_activity_mon #(
            .SYNC_STAGES    (SYNC_STAGES),
            .LOSS_WINDOWS   (LOSS_WINDOWS),
            .RETURN_WINDOWS (RETURN_WINDOWS)
        ) u_mon (
            .clk        (clk),
            .rst_n      (rst_n),
            .ref_in     (ref_vec[g]),
            .window_end (window_end),
            .present    (pres[g]),
            .qualified  (qual[g])
        );
    end

    always_comb begin
        next_pri = sel_q.use_pri;
        if (!auto_mode) begin
            next_pri = sel_pin;
        end else if (sel_q.use_pri) begin
            if (!pres[PRI_IDX] && pres[SEC_IDX]) next_pri = 1'b0;
        end else begin
            if (pres[PRI_IDX] && (qual[PRI_IDX] || !pres[SEC_IDX])) next_pri = 1'b1;
        end
        sel_d.use_pri = next_pri;
        sel_d.sw_evt  = (next_pri != sel_q.use_pri);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q.use_pri <= 1'b1;
            sel_q.sw_evt  <= 1'b0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign use_primary  = sel_q.use_pri;
    assign switch_event = sel_q.sw_evt;
    assign pri_valid    = pres[PRI_IDX];
    assign sec_valid    = pres[SEC_IDX];
    assign no_reference = ~|pres;
endmodule

// File: rtl/refsel_checker.sv
module refsel_checker (
    input logic clk,
    input logic rst_n,
    input logic sel_pin,
    input logic auto_mode,
    input logic use_primary,
    input logic pri_valid,
    input logic sec_valid,
    input logic no_reference,
    input logic switch_event
);
    assert_manual_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode |=> (use_primary == $past(sel_pin)));

    assert_pri_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && pri_valid && use_primary) |=> use_primary);

    assert_sec_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && !use_primary && sec_valid && !pri_valid) |=> !use_primary);

    assert_noref_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && no_reference) |=> $stable(use_primary));

    assert_noref_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        no_reference |-> (!pri_valid && !sec_valid));

    assert_change_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (use_primary != $past(use_primary)) |-> switch_event);

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        switch_event |-> (use_primary != $past(use_primary)));
endmodule

bind refclk_priority_selector refsel_checker u_chk (.*);

// File: tb/refclk_priority_selector_test.sv
module refclk_priority_selector_test;
    localparam int WIN = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pri_ref = 1'b0;
    logic sec_ref = 1'b0;
    logic sel_pin = 1'b1;
    logic auto_mode = 1'b0;
    logic pri_en = 1'b0;
    logic sec_en = 1'b0;
    logic use_primary, pri_valid, sec_valid, no_reference, switch_event;

    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic exp_q[$];

    refclk_priority_selector uut (
        .clk(clk), .rst_n(rst_n), .pri_ref(pri_ref), .sec_ref(sec_ref),
        .sel_pin(sel_pin), .auto_mode(auto_mode), .use_primary(use_primary),
        .pri_valid(pri_valid), .sec_valid(sec_valid),
        .no_reference(no_reference), .switch_event(switch_event)
    );

    always #4 clk = ~clk;
    always begin #40; if (pri_en) pri_ref = ~pri_ref; end
    always begin #28; if (sec_en) sec_ref = ~sec_ref; end

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_switch(logic v);
        exp_q.push_back(v);
    endtask

    // monitor: every switch pulse must match a queued expectation
    always @(negedge clk) begin
        if (rst_n && switch_event) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected switch", use_primary, ~use_primary);
            end else begin
                check("R9 switch value", use_primary, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(4);
        check("R1 use_primary", use_primary, 1'b1);
        check("R1 switch_event", switch_event, 1'b0);
        check("R1 pri_valid", pri_valid, 1'b0);
        check("R1 sec_valid", sec_valid, 1'b0);
        check("R1 no_reference", no_reference, 1'b1);
        rst_n = 1'b1;
        cyc(1);
        check("R1 after release", use_primary, 1'b1);

        // R2 manual follows pin
        sel_pin = 1'b0; expect_switch(1'b0);
        cyc(1);
        check("R2 pin 0 secondary", use_primary, 1'b0);
        cyc(3);
        sel_pin = 1'b1; expect_switch(1'b1);
        cyc(1);
        check("R2 pin 1 primary", use_primary, 1'b1);

        // R4 references come up
        pri_en = 1'b1; sec_en = 1'b1;
        cyc(2 * WIN + 20);
        check("R4 pri_valid", pri_valid, 1'b1);
        check("R4 sec_valid", sec_valid, 1'b1);
        check("R8 no_reference clear", no_reference, 1'b0);

        // R3 auto mode ignores pin
        auto_mode = 1'b1;
        for (int i = 0; i < 40; i++) begin
            sel_pin = ~sel_pin;
            cyc(1);
        end
        check("R3 pin ignored", use_primary, 1'b1);
        sel_pin = 1'b0;
        cyc(WIN);
        check("R3 pin 0 ignored", use_primary, 1'b1);

        // R5/R6 primary loss -> failover
        pri_en = 1'b0;
        cyc(WIN - 10);
        check("R5 one empty window keeps valid", pri_valid, 1'b1);
        check("R6 still primary", use_primary, 1'b1);
        expect_switch(1'b0);
        cyc(3 * WIN);
        check("R5 pri lost", pri_valid, 1'b0);
        check("R6 failover to secondary", use_primary, 1'b0);

        // R7 return hysteresis
        pri_en = 1'b1;
        cyc(2 * WIN + 20);
        check("R4 pri back valid", pri_valid, 1'b1);
        check("R7 not yet returned", use_primary, 1'b0);
        expect_switch(1'b1);
        cyc(4 * WIN);
        check("R7 returned to primary", use_primary, 1'b1);

        // R8 lose both: secondary first, then primary
        sec_en = 1'b0;
        cyc(4 * WIN);
        check("R5 sec lost", sec_valid, 1'b0);
        check("R6 primary kept", use_primary, 1'b1);
        pri_en = 1'b0;
        cyc(4 * WIN);
        check("R8 no_reference set", no_reference, 1'b1);
        check("R8 selection held", use_primary, 1'b1);
        sel_pin = 1'b0;
        cyc(WIN);
        check("R8 held with pin 0", use_primary, 1'b1);

        // R6 only secondary returns
        expect_switch(1'b0);
        sec_en = 1'b1;
        cyc(3 * WIN);
        check("R6 secondary taken", use_primary, 1'b0);
        check("R8 no_reference clear again", no_reference, 1'b0);

        // R2 back to manual
        auto_mode = 1'b0; sel_pin = 1'b1; expect_switch(1'b1);
        cyc(1);
        check("R2 manual primary", use_primary, 1'b1);
        cyc(2);
        check("R9 pulse ended", switch_event, 1'b0);
        check("R9 queue drained", exp_q.size() == 0, 1'b1);
        finish_run();
    end
endmodule